// File: doc/BRIEF.md
# Gain Status Snapshot and Live Status Register Bank

This block is a small read-only status bank that sits behind a byte-wide host register port in a video decoder. It exposes two kinds of status. The first is a gain-status word of 16 bits, split over two byte addresses. It carries a 12-bit fine gain and a 4-bit coarse gain from the sync-channel gain loop. The second is a single status byte built straight from the live detector outputs. That byte carries signal presence, weak-signal mode, PAL switch polarity, field parity, colour-killer state and a copy-protection code.

The gain word is never read live. The host writes 1 to bit 0 of a request register. On the next clock the block copies fine and coarse gain together into a snapshot and drops the request bit, which tells the host that the snapshot is ready. The snapshot then stays frozen until the next request, so the host can read the two bytes in any order with no risk of a torn value. Copies are taken only while automatic gain control is on. In manual mode a request still completes, so polling never stalls, but the stored values stay as they were.

The register map uses these addresses: 0x10 status byte, 0x11 gain low byte, 0x12 gain high byte, 0x20 request register.

Top module: `gain_status_bank`

## Requirements
- R1: After reset the request bit reads 0, the gain low byte reads 0x00 and the gain high byte reads 0x58, which is coarse code 0101 with fine code 0x800 (unity on both).
- R2: Address 0x10 reads the live status byte at once. Bit 7 is signal present, bit 6 weak signal, bit 5 PAL switch polarity, bit 4 odd field (1 = odd), bit 3 colour killer active, and bits 2:0 the copy-protection code (000 none, 001 AGC pulses, 010 2-line stripe, 011 pulses plus 2-line, 110 4-line stripe, 111 pulses plus 4-line).
- R3: Address 0x11 reads snapshot fine gain bits 7:0. Address 0x12 reads snapshot coarse gain in bits 7:4 and fine gain bits 11:8 in bits 3:0.
- R4: Writing a byte with bit 0 set to address 0x20 sets the request bit. Address 0x20 reads {7'b0, request}. A set request bit clears at the very next clock edge.
- R5: While gain control is automatic, the clock edge that clears the request loads fine and coarse gain into the snapshot, both taken in that same cycle.
- R6: While the request bit is 0, the snapshot does not change, whatever the live gain inputs do.
- R7: In manual gain mode a request still clears after one cycle, but it leaves the snapshot unchanged.
- R8: Writes to 0x10, 0x11 and 0x12 have no effect. A write to 0x20 with bit 0 clear does not set the request.
- R9: A read of any address outside the map returns 0x00.
- R10: A request written while another is pending merges into that capture. The request still clears on schedule, and no second capture follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| agcEnable | input | 1 | 1 = automatic gain control, 0 = manual gain |
| liveFine | input | 12 | Live fine gain from the gain loop |
| liveCoarse | input | 4 | Live coarse gain from the gain loop |
| sigPresent | input | 1 | Signal detected |
| weakSig | input | 1 | Weak-signal mode active |
| palSwitch | input | 1 | PAL switch polarity of the first odd-field line |
| oddField | input | 1 | Current field is odd |
| colorKill | input | 1 | Colour killer active |
| copyProt | input | 3 | Copy-protection detection code |
| regAddr | input | 8 | Register address for both read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for regAddr |

## Verification
Four rules are checked on every clock by the bound properties. The request always clears one cycle after it is set. A capture with automatic gain control loads exactly the previous cycle's live gains. The snapshot holds while no request is pending, and also when a request arrives in manual mode. The read mux returns the live status byte at its address and zero at unmapped ones. Some behaviour can only be shown through the bench's register-level scenarios. These are the reset values, which writes are ignored, a second request merging into a pending one, and the snapshot staying unchanged across reads in either byte order while the live gains move.

// File: rtl/gain_status_pkg.sv
package gain_status_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int FINE_W   = 12;
  localparam int COARSE_W = 4;
  localparam int PROT_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_GAIN_LO = 8'h11;
  localparam logic [ADDR_W-1:0] ADDR_GAIN_HI = 8'h12;
  localparam logic [ADDR_W-1:0] ADDR_REQUEST = 8'h20;

  localparam logic [FINE_W-1:0]   FINE_UNITY   = 12'h800;
  localparam logic [COARSE_W-1:0] COARSE_UNITY = 4'b0101;

  localparam int FINE_HI_W = FINE_W - DATA_W;

  typedef struct packed {
    logic capture;   // load snapshot this edge
    logic pending;   // request outstanding
  } ctrlStrobes_t;
endpackage

// File: rtl/gain_status_ctrl.sv
module gain_status_ctrl
  import gain_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              agcEnable,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobes_t      strobes
);
  logic reqFlag;
  logic reqWrite;

  // a new request counts only when none is pending; a pending one clears
  assign reqWrite = wrEn && (regAddr == ADDR_REQUEST) && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqFlag <= 1'b0;
    end else if (reqFlag) begin
      reqFlag <= 1'b0;
    end else if (reqWrite) begin
      reqFlag <= 1'b1;
    end
  end

  always_comb begin
    strobes.pending = reqFlag;
    strobes.capture = reqFlag && agcEnable;
  end
endmodule

// File: rtl/gain_status_datapath.sv
module gain_status_datapath
  import gain_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [FINE_W-1:0]   liveFine,
  input  logic [COARSE_W-1:0] liveCoarse,
  input  logic [DATA_W-1:0]   statusByte,
  input  logic [ADDR_W-1:0]   regAddr,
  output logic [FINE_W-1:0]   snapFine,
  output logic [COARSE_W-1:0] snapCoarse,
  output logic [DATA_W-1:0]   rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapFine   <= FINE_UNITY;
      snapCoarse <= COARSE_UNITY;
    end else if (strobes.capture) begin
      snapFine   <= liveFine;
      snapCoarse <= liveCoarse;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_STATUS:  rdData = statusByte;
      ADDR_GAIN_LO: rdData = snapFine[DATA_W-1:0];
      ADDR_GAIN_HI: rdData = {snapCoarse, snapFine[FINE_W-1 -: FINE_HI_W]};
      ADDR_REQUEST: rdData = {{(DATA_W-1){1'b0}}, strobes.pending};
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/gain_status_bank.sv
module gain_status_bank
  import gain_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              agcEnable,
  input  logic [11:0]       liveFine,
  input  logic [3:0]        liveCoarse,
  input  logic              sigPresent,
  input  logic              weakSig,
  input  logic              palSwitch,
  input  logic              oddField,
  input  logic              colorKill,
  input  logic [2:0]        copyProt,
  input  logic [7:0]        regAddr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  ctrlStrobes_t        strobes;
  logic                reqFlag;
  logic [FINE_W-1:0]   snapFine;
  logic [COARSE_W-1:0] snapCoarse;
  logic [DATA_W-1:0]   statusByte;

  assign statusByte = {sigPresent, weakSig, palSwitch, oddField, colorKill, copyProt};
  assign reqFlag    = strobes.pending;

  gain_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .agcEnable(agcEnable),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .strobes(strobes)
  );

  gain_status_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .liveFine(liveFine), .liveCoarse(liveCoarse), .statusByte(statusByte),
    .regAddr(regAddr), .snapFine(snapFine), .snapCoarse(snapCoarse), .rdData(rdData)
  );
endmodule

// File: rtl/gain_status_chk.sv
module gain_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        agcEnable,
  input logic        reqFlag,
  input logic [11:0] liveFine,
  input logic [3:0]  liveCoarse,
  input logic [11:0] snapFine,
  input logic [3:0]  snapCoarse,
  input logic [7:0]  regAddr,
  input logic [7:0]  rdData,
  input logic        sigPresent,
  input logic        weakSig,
  input logic        palSwitch,
  input logic        oddField,
  input logic        colorKill,
  input logic [2:0]  copyProt
);
  p_req_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqFlag |=> !reqFlag);

  p_capture_same_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqFlag && agcEnable) |=>
      (snapFine == $past(liveFine) && snapCoarse == $past(liveCoarse)));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !reqFlag |=> $stable({snapFine, snapCoarse}));

  p_manual_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqFlag && !agcEnable) |=> $stable({snapFine, snapCoarse}));

  p_status_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'h10) |->
      rdData == {sigPresent, weakSig, palSwitch, oddField, colorKill, copyProt});

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(regAddr inside {8'h10, 8'h11, 8'h12, 8'h20}) |-> rdData == 8'h00);
endmodule

bind gain_status_bank gain_status_chk u_chk (
  .clk(clk), .rstN(rstN), .agcEnable(agcEnable), .reqFlag(reqFlag),
  .liveFine(liveFine), .liveCoarse(liveCoarse),
  .snapFine(snapFine), .snapCoarse(snapCoarse),
  .regAddr(regAddr), .rdData(rdData),
  .sigPresent(sigPresent), .weakSig(weakSig), .palSwitch(palSwitch),
  .oddField(oddField), .colorKill(colorKill), .copyProt(copyProt)
);

// File: tb/gain_status_bank_bench.sv
module gain_status_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        agcEnable = 1'b1;
  logic [11:0] liveFine = 12'h000;
  logic [3:0]  liveCoarse = 4'h0;
  logic        sigPresent = 0, weakSig = 0, palSwitch = 0, oddField = 0, colorKill = 0;
  logic [2:0]  copyProt = 3'b000;
  logic [7:0]  regAddr = 8'h00;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;

  always #2 clk = ~clk;

  gain_status_bank u_gain_status_bank (.*);

  typedef struct {
    logic [7:0] expVal;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  event sampleEv;

  // monitor: compares read data against queued expectations
  always @(sampleEv) begin
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (rdData !== it.expVal) begin
        errors++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, rdData, it.expVal);
      end
    end
  end

  task automatic expectRead(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = addr;
    expQ.push_back('{exp, tag});
    #1 -> sampleEv;
    #0;
  endtask

  task automatic hostWrite(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    regAddr = addr; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [7:0] hiByte(input logic [3:0] c, input logic [11:0] f);
    return {c, f[11:8]};
  endfunction

  initial begin
    #150000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    expectRead(8'h20, 8'h00, "R1 request after reset");
    expectRead(8'h11, 8'h00, "R1 gain low after reset");
    expectRead(8'h12, 8'h58, "R1 gain high after reset");

    // R2 status byte, two patterns
    sigPresent = 1; weakSig = 0; palSwitch = 1; oddField = 0; colorKill = 1; copyProt = 3'b011;
    expectRead(8'h10, 8'b1010_1011, "R2 status pattern A");
    sigPresent = 0; weakSig = 1; palSwitch = 0; oddField = 1; colorKill = 0; copyProt = 3'b110;
    expectRead(8'h10, 8'b0101_0110, "R2 status pattern B");

    // R4/R5 capture in automatic mode
    liveFine = 12'hA5C; liveCoarse = 4'hF;
    hostWrite(8'h20, 8'h01);                 // flag set at write edge; now past next edge
    expectRead(8'h20, 8'h00, "R4 request cleared after one cycle");
    expectRead(8'h11, 8'h5C, "R3 R5 gain low captured");
    expectRead(8'h12, hiByte(4'hF, 12'hA5C), "R3 R5 gain high captured");

    // R4 flag visible for exactly one cycle
    @(negedge clk); regAddr = 8'h20; wrData = 8'hFF; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    // write edge passed, flag set until next edge
    expQ.push_back('{8'h01, "R4 request reads set"}); #1 -> sampleEv; #0;
    expectRead(8'h20, 8'h00, "R4 request self-clears");

    // R6 live gain moves, snapshot holds; read high first then low
    liveFine = 12'h123; liveCoarse = 4'h2;
    repeat (3) @(negedge clk);
    expectRead(8'h12, hiByte(4'hF, 12'hA5C), "R6 high holds");
    expectRead(8'h11, 8'h5C, "R6 low holds");

    // R8 ignored writes
    hostWrite(8'h11, 8'hEE);
    hostWrite(8'h12, 8'hEE);
    hostWrite(8'h10, 8'hEE);
    hostWrite(8'h20, 8'hFE);
    expectRead(8'h20, 8'h00, "R8 write without bit0 leaves request clear");
    expectRead(8'h11, 8'h5C, "R8 gain low unchanged by write");
    expectRead(8'h12, hiByte(4'hF, 12'hA5C), "R8 gain high unchanged by write");
    expectRead(8'h10, 8'b0101_0110, "R8 status unchanged by write");

    // R9 unmapped reads
    expectRead(8'h00, 8'h00, "R9 unmapped 0x00");
    expectRead(8'h13, 8'h00, "R9 unmapped 0x13");
    expectRead(8'hFF, 8'h00, "R9 unmapped 0xFF");

    // R7 manual mode
    agcEnable = 1'b0; liveFine = 12'h3C7; liveCoarse = 4'h6;
    hostWrite(8'h20, 8'h01);
    expectRead(8'h20, 8'h00, "R7 request clears in manual mode");
    expectRead(8'h11, 8'h5C, "R7 manual gain low unchanged");
    expectRead(8'h12, hiByte(4'hF, 12'hA5C), "R7 manual gain high unchanged");

    // R10 merged request: capture at second write's edge, none after
    agcEnable = 1'b1; liveFine = 12'h4D2; liveCoarse = 4'h9;
    @(negedge clk); regAddr = 8'h20; wrData = 8'h01; wrEn = 1'b1;
    @(negedge clk);                           // flag set; second write pending
    @(negedge clk); wrEn = 1'b0;              // capture + clear at that edge
    liveFine = 12'hFFF; liveCoarse = 4'h0;
    repeat (2) @(negedge clk);
    expectRead(8'h20, 8'h00, "R10 request cleared after merge");
    expectRead(8'h11, 8'hD2, "R10 single capture low");
    expectRead(8'h12, hiByte(4'h9, 12'h4D2), "R10 single capture high");

    // R5 extreme codes
    liveFine = 12'hFFF; liveCoarse = 4'hF;
    hostWrite(8'h20, 8'h01);
    expectRead(8'h11, 8'hFF, "R5 max fine low");
    expectRead(8'h12, 8'hFF, "R5 max gain high");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule